// File: doc/BRIEF.md
# Region-Sequenced Line Pulse Generator

This block produces one programmable timing pulse per video line, such as a clamp window or a blanking window. A pixel counter runs across each line and a line counter runs down the field. Four pulse shapes are stored. Each shape has a start level and two toggle positions. Up to four line regions, bounded by programmable change positions, each pick one of the stored shapes through a 2-bit pointer. One field can therefore use different pulse shapes at the top, in the middle and at the bottom.

Software writes a shadow register set through a simple single-cycle write port. The shadow set is copied into the working set at every line-start strobe. A pulse in progress is never altered partway through a line.

Top module: `line_pulse_seq`

## Requirements
- R1: While `rst` is high, `pulse_out` is 1. After reset, every register holds its reset value: start levels all 1, toggle positions all 0xFFF, change positions 1 to 3 at 0xFFF, and the pointer register at 0, so every region uses shape 0.
- R2: On the first pixel of a line, the output level equals the start-level bit of the selected shape. Start-level bit s lives in bit s of the level register at address 0. The level for pixel p appears on `pulse_out` one clock after the cycle in which the pixel count is p.
- R3: The output inverts at the pixel whose count equals toggle position A of the selected shape. Shape s keeps position A in bits [11:0] of address 1+s.
- R4: The output inverts again at the pixel equal to toggle position B, held in bits [23:12] of address 1+s. If A and B are equal, the two inversions cancel and the level does not change.
- R5: A toggle position of 0xFFF is never matched. A shape left at its reset value holds its start level for the whole line.
- R6: The active region is the highest k whose change position is enabled and not above the line count. Region k uses the shape in bits [2k+1:2k] of the pointer register at address 5. Change position 0 is fixed at 0 and cannot be written. Change positions 1, 2 and 3 live in bits [11:0] of addresses 6, 7 and 8.
- R7: A change position of 0xFFF disables its region, so lines that would fall in it stay in the region below.
- R8: A line-start strobe sets the pixel count to 0, and each clock after that adds one. A field-start strobe sets the line count to 0, and every other line-start strobe adds one to it.
- R9: A write changes only the shadow set. The new value affects the output from the next line-start strobe, never the line in progress.
- R10: A write to an address outside 0 to 8 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe that starts a line |
| field_start | input | 1 | One-cycle strobe that starts a field, given together with line_start |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 24 | Register write data |
| pulse_out | output | 1 | Registered line pulse |

## Verification
The hardest case to reach is a line count that falls exactly on a change position while the pointer sends each region to a different shape. A disabled upper region must also be shown to leave its lines in the region below. The stimulus programs three shapes that are easy to tell apart and sets close change positions. It then runs whole fields of short lines, first with the top region disabled and then with it enabled. A write during a line is also issued, to show that it only affects the following line.

// File: rtl/lps_pkg.sv
package lps_pkg;

  // Register address helpers, parameterised on the number of stored shapes.
  // Address 0 holds the start levels, followed by one word per shape, then
  // the pointer word, then the change positions 1 and up.
  localparam int unsigned LVL_ADDR = 0;

  function automatic int unsigned shape_addr(input int unsigned s);
    return 1 + s;
  endfunction

  function automatic int unsigned ptr_addr(input int unsigned nshape);
    return 1 + nshape;
  endfunction

  function automatic int unsigned chg_addr(input int unsigned nshape, input int unsigned k);
    return 1 + nshape + k;
  endfunction

endpackage

// File: rtl/lps_counters.sv
module lps_counters #(
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             field_start,
  output logic [POS_W-1:0] pix_cnt,
  output logic [POS_W-1:0] line_cnt
);

  localparam logic [POS_W-1:0] SAT = '1;

  // Pixel position inside the line; it saturates so that SAT is never passed.
  always_ff @(posedge clk) begin
    if (rst)
      pix_cnt <= '0;
    else if (line_start)
      pix_cnt <= '0;
    else if (pix_cnt != SAT)
      pix_cnt <= pix_cnt + 1'b1;
  end

  // Line position inside the field.
  always_ff @(posedge clk) begin
    if (rst)
      line_cnt <= '0;
    else if (field_start)
      line_cnt <= '0;
    else if (line_start && line_cnt != SAT)
      line_cnt <= line_cnt + 1'b1;
  end

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (rst)
    (!line_start && pix_cnt != SAT) |=> pix_cnt == $past(pix_cnt) + 1'b1); // R8

  AST_LINE_ZERO: assert property (@(posedge clk) disable iff (rst)
    field_start |=> line_cnt == '0); // R8

endmodule

// File: rtl/lps_regfile.sv
module lps_regfile
  import lps_pkg::*;
#(
  parameter int POS_W      = 12,
  parameter int SHAPES     = 4,
  parameter int REGIONS    = 4,
  parameter int ADDR_W     = 4,
  parameter int SEL_W      = $clog2(SHAPES)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             line_start,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [2*POS_W-1:0]               wr_data,
  output logic [SHAPES-1:0]                act_lvl,
  output logic [SHAPES-1:0][POS_W-1:0]     act_ta,
  output logic [SHAPES-1:0][POS_W-1:0]     act_tb,
  output logic [REGIONS*SEL_W-1:0]         act_ptr,
  output logic [REGIONS-1:0][POS_W-1:0]    act_chg
);

  logic [SHAPES-1:0]             sh_lvl;
  logic [SHAPES-1:0][POS_W-1:0]  sh_ta;
  logic [SHAPES-1:0][POS_W-1:0]  sh_tb;
  logic [REGIONS*SEL_W-1:0]      sh_ptr;
  logic [REGIONS-1:0][POS_W-1:0] sh_chg;

  // Shadow set: written by software at any time. Change position 0 is
  // fixed at zero and has no address.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_lvl <= '1;
      sh_ta  <= '1;
      sh_tb  <= '1;
      sh_ptr <= '0;
      for (int k = 0; k < REGIONS; k++)
        sh_chg[k] <= (k == 0) ? '0 : '1;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(LVL_ADDR))
        sh_lvl <= wr_data[SHAPES-1:0];
      for (int s = 0; s < SHAPES; s++) begin
        if (wr_addr == ADDR_W'(shape_addr(s))) begin
          sh_ta[s] <= wr_data[POS_W-1:0];
          sh_tb[s] <= wr_data[2*POS_W-1:POS_W];
        end
      end
      if (wr_addr == ADDR_W'(ptr_addr(SHAPES)))
        sh_ptr <= wr_data[REGIONS*SEL_W-1:0];
      for (int k = 1; k < REGIONS; k++) begin
        if (wr_addr == ADDR_W'(chg_addr(SHAPES, k)))
          sh_chg[k] <= wr_data[POS_W-1:0];
      end
    end
  end

  // Working set: copied from the shadow set only at a line boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_lvl <= '1;
      act_ta  <= '1;
      act_tb  <= '1;
      act_ptr <= '0;
      for (int k = 0; k < REGIONS; k++)
        act_chg[k] <= (k == 0) ? '0 : '1;
    end else if (line_start) begin
      act_lvl <= sh_lvl;
      act_ta  <= sh_ta;
      act_tb  <= sh_tb;
      act_ptr <= sh_ptr;
      act_chg <= sh_chg;
    end
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> ($stable(act_lvl) && $stable(act_ta) && $stable(act_tb)
                     && $stable(act_ptr) && $stable(act_chg))); // R9

  AST_CHG0_ZERO: assert property (@(posedge clk) disable iff (rst)
    act_chg[0] == '0); // R6

endmodule

// File: rtl/lps_region_sel.sv
module lps_region_sel #(
  parameter int POS_W   = 12,
  parameter int REGIONS = 4,
  parameter int SEL_W   = 2,
  parameter int RSEL_W  = $clog2(REGIONS)
) (
  input  logic [POS_W-1:0]              line_cnt,
  input  logic [REGIONS-1:0][POS_W-1:0] chg,
  input  logic [REGIONS*SEL_W-1:0]      ptr,
  output logic [RSEL_W-1:0]             region,
  output logic [SEL_W-1:0]              shape_sel
);

  localparam logic [POS_W-1:0] OFF = '1;

  logic [REGIONS-1:0] reached;

  // A region is reached once the line count has arrived at its change
  // position; a position of all ones marks the region as unused.
  for (genvar k = 0; k < REGIONS; k++) begin : g_cmp
    assign reached[k] = (chg[k] != OFF) && (line_cnt >= chg[k]);
  end

  // The highest reached region wins.
  always_comb begin
    region = '0;
    for (int k = 0; k < REGIONS; k++)
      if (reached[k])
        region = RSEL_W'(k);
  end

  assign shape_sel = ptr[region*SEL_W +: SEL_W];

endmodule

// File: rtl/line_pulse_seq.sv
module line_pulse_seq #(
  parameter int POS_W   = 12,
  parameter int SHAPES  = 4,
  parameter int REGIONS = 4,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_start,
  input  logic               field_start,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [2*POS_W-1:0] wr_data,
  output logic               pulse_out
);

  localparam int SEL_W  = $clog2(SHAPES);
  localparam int RSEL_W = $clog2(REGIONS);
  localparam logic [POS_W-1:0] NEVER = '1;

  logic [POS_W-1:0]              pix_cnt, line_cnt;
  logic [SHAPES-1:0]             act_lvl;
  logic [SHAPES-1:0][POS_W-1:0]  act_ta, act_tb;
  logic [REGIONS*SEL_W-1:0]      act_ptr;
  logic [REGIONS-1:0][POS_W-1:0] act_chg;
  logic [RSEL_W-1:0]             region;
  logic [SEL_W-1:0]              shape_sel;
  logic                          sel_lvl;
  logic [POS_W-1:0]              sel_ta, sel_tb;
  logic                          hit_a, hit_b, flip_now;
  logic                          flips, first_pix;

  lps_counters #(.POS_W(POS_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .field_start(field_start),
    .pix_cnt    (pix_cnt),
    .line_cnt   (line_cnt)
  );

  lps_regfile #(
    .POS_W  (POS_W),
    .SHAPES (SHAPES),
    .REGIONS(REGIONS),
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .line_start(line_start),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .act_lvl   (act_lvl),
    .act_ta    (act_ta),
    .act_tb    (act_tb),
    .act_ptr   (act_ptr),
    .act_chg   (act_chg)
  );

  lps_region_sel #(
    .POS_W  (POS_W),
    .REGIONS(REGIONS),
    .SEL_W  (SEL_W),
    .RSEL_W (RSEL_W)
  ) u_rsel (
    .line_cnt (line_cnt),
    .chg      (act_chg),
    .ptr      (act_ptr),
    .region   (region),
    .shape_sel(shape_sel)
  );

  assign sel_lvl  = act_lvl[shape_sel];
  assign sel_ta   = act_ta[shape_sel];
  assign sel_tb   = act_tb[shape_sel];
  assign hit_a    = (pix_cnt != NEVER) && (pix_cnt == sel_ta);
  assign hit_b    = (pix_cnt != NEVER) && (pix_cnt == sel_tb);
  assign flip_now = hit_a ^ hit_b;

  // Parity of inversions already taken on this line.
  always_ff @(posedge clk) begin
    if (rst || line_start)
      flips <= 1'b0;
    else
      flips <= flips ^ flip_now;
  end

  always_ff @(posedge clk) begin
    if (rst)
      first_pix <= 1'b0;
    else
      first_pix <= line_start;
  end

  always_ff @(posedge clk) begin
    if (rst)
      pulse_out <= 1'b1;
    else
      pulse_out <= sel_lvl ^ flips ^ flip_now;
  end

  AST_FIRST_PIX_ZERO: assert property (@(posedge clk) disable iff (rst)
    first_pix |-> pix_cnt == '0); // R8

  AST_START_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (first_pix && !flip_now) |=> pulse_out == $past(sel_lvl)); // R2

  AST_TOGGLE_INVERTS: assert property (@(posedge clk) disable iff (rst)
    (!first_pix && flip_now) |=> pulse_out != $past(pulse_out)); // R3

  AST_NO_MATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!first_pix && !flip_now) |=> $stable(pulse_out)); // R5

endmodule

// File: tb/tb_line_pulse_seq.sv
module tb_line_pulse_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NEVER = 4095;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_start = 1'b0;
  logic        field_start = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic        pulse_out;

  line_pulse_seq dut (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .field_start(field_start),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pulse_out  (pulse_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    cyc;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Shadow and working copies of the settings, kept from the requirements.
  logic [3:0] m_lvl, a_lvl;
  int         m_ta[4], m_tb[4], a_ta[4], a_tb[4];
  logic [7:0] m_ptr, a_ptr;
  int         m_chg[4], a_chg[4];
  int         m_line;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops each expected item in the cycle it is due.
  always @(negedge clk) begin
    if (!rst) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (e.cyc != cyc || pulse_out !== e.val) begin
          n_bad++;
          $display("FAIL %s cyc=%0d due=%0d actual=%0b expected=%0b",
                   e.tag, cyc, e.cyc, pulse_out, e.val);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  function automatic void mdl_reset();
    m_lvl = 4'hF;
    m_ptr = 8'h00;
    for (int i = 0; i < 4; i++) begin
      m_ta[i] = NEVER;
      m_tb[i] = NEVER;
      m_chg[i] = (i == 0) ? 0 : NEVER;
    end
    m_line = 0;
  endfunction

  function automatic void mdl_write(input int a, input logic [23:0] d);
    if (a == 0) m_lvl = d[3:0];
    else if (a >= 1 && a <= 4) begin
      m_ta[a-1] = int'(d[11:0]);
      m_tb[a-1] = int'(d[23:12]);
    end
    else if (a == 5) m_ptr = d[7:0];
    else if (a >= 6 && a <= 8) m_chg[a-5] = int'(d[11:0]);
  endfunction

  function automatic logic level_at(input int p);
    int rg;
    int s;
    logic lv;
    rg = 0;
    for (int k = 1; k < 4; k++)
      if (a_chg[k] != NEVER && m_line >= a_chg[k]) rg = k;
    s  = int'(a_ptr[2*rg +: 2]);
    lv = a_lvl[s];
    if (a_ta[s] != NEVER && a_ta[s] <= p) lv = ~lv;
    if (a_tb[s] != NEVER && a_tb[s] <= p) lv = ~lv;
    return lv;
  endfunction

  // Called at a negedge.
  task automatic wr(input int a, input logic [23:0] d);
    wr_en = 1'b1;
    wr_addr = 4'(a);
    wr_data = d;
    mdl_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Runs one line of len pixels; optionally writes during the line at pixel wat.
  task automatic run_line(input int len, input bit fs, input string tag,
                          input int wat, input int wa, input logic [23:0] wd);
    int base;
    base = cyc;
    line_start = 1'b1;
    field_start = fs;
    if (fs) m_line = 0; else m_line++;
    a_lvl = m_lvl;
    a_ptr = m_ptr;
    for (int i = 0; i < 4; i++) begin
      a_ta[i] = m_ta[i];
      a_tb[i] = m_tb[i];
      a_chg[i] = m_chg[i];
    end
    for (int p = 0; p < len; p++) begin
      exp_t e;
      e.cyc = base + 2 + p;
      e.val = level_at(p);
      e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk);
    line_start = 1'b0;
    field_start = 1'b0;
    for (int i = 1; i < len; i++) begin
      if (i == wat) begin
        wr_en = 1'b1;
        wr_addr = 4'(wa);
        wr_data = wd;
        mdl_write(wa, wd);
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    mdl_reset();
    repeat (3) @(negedge clk);
    n_cmp++;
    if (pulse_out !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 reset level actual=%0b expected=1", pulse_out);
    end
    rst = 1'b0;
    @(negedge clk);

    // R1, R5: defaults hold the start level of 1 through the line
    run_line(16, 1'b1, "R1_R5 defaults", -1, 0, '0);

    // R2, R3, R4: shape 0 starts low, toggles at 5 and at the last pixel 19
    wr(0, 24'h00000E);
    wr(1, {12'd19, 12'd5});
    run_line(20, 1'b1, "R2_R3_R4 shape0", -1, 0, '0);
    run_line(12, 1'b0, "R8 short line", -1, 0, '0);

    // R4: equal positions cancel; R6: regions via pointer bits
    wr(2, {12'd7, 12'd7});
    wr(3, {12'hFFF, 12'd3});
    wr(4, {12'hFFF, 12'd0});
    wr(6, 24'd2);
    wr(7, 24'd4);
    wr(5, 24'h0000E4);
    run_line(10, 1'b1, "R6 region0", -1, 0, '0);
    for (int l = 1; l < 6; l++)
      run_line(10, 1'b0, "R6_R7_R4 regions, top off", -1, 0, '0);

    // R7: enable the top region at line 5
    wr(8, 24'd5);
    run_line(10, 1'b1, "R7 region0", -1, 0, '0);
    for (int l = 1; l < 7; l++)
      run_line(10, 1'b0, "R7 top region on", -1, 0, '0);

    // R8: field start brings back region 0
    run_line(10, 1'b1, "R8 field restart", -1, 0, '0);
    run_line(9, 1'b0, "R8 second line", -1, 0, '0);

    // R9: a write during the line only affects the next line
    wr(5, 24'h000000);
    run_line(20, 1'b1, "R9 before write", 8, 1, {12'hFFF, 12'd2});
    run_line(20, 1'b0, "R9 after write", -1, 0, '0);

    // R10: unused addresses change nothing
    wr(15, 24'h000000);
    wr(9, 24'h000000);
    run_line(20, 1'b0, "R10 unused address", -1, 0, '0);
    run_line(4, 1'b1, "R10 tail", -1, 0, '0);

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", q.size());
    end
    finish_run();
  end

endmodule